// File: doc/BRIEF.md
# Process-Tagged Translation Cache

This block caches recent page-to-frame translations so that a memory access does not have to consult the page table held in memory. Each entry holds a virtual page number, the process identifier that owns it, the physical frame number and three access flags: writable, referenced and dirty. A lookup compares the requested page number and the current process identifier against every entry in parallel. On a hit it returns, in the same cycle, the physical address and the flags. On a miss it raises a trap so that software can install the missing translation.

Software, or an external page-table walker, installs an entry through a fill port, one entry per cycle. An installed pair of page and process that is already cached overwrites its old entry in place. Otherwise the fill lands in the lowest-numbered empty slot, or, once every slot is full, in the slot named by a rotating victim pointer. Because entries carry an owner tag, translations from several processes can live side by side. A context switch only needs a new value on the current-process input. Two clearing commands are provided. One wipes the whole cache. The other drops only the entries owned by the current process.

Top module: `ptag_tlb`

## Requirements
- R1: After reset every slot is empty, and any lookup misses.
- R2: A lookup whose page number and current process identifier match a valid entry raises the hit output in the same cycle. The physical address is then the frame number in the upper bits, concatenated above the untouched page offset in the lower bits, and the entry's writable, referenced and dirty flags are returned as stored before this lookup.
- R3: A lookup that matches no valid entry raises the miss-trap output with hit low. With no lookup requested, neither hit, miss-trap, fault nor dirty-set is raised.
- R4: An entry hits only when its owner tag equals the current process identifier. The same page number may be cached for different processes at once, each returning its own frame.
- R5: A fill becomes visible to lookups from the cycle after it is applied. When it matches no cached pair and some slot is empty, it goes into the lowest-numbered empty slot.
- R6: When every slot is full, a fill of a new pair evicts the slot named by a victim pointer. The pointer starts at slot 0 after reset, advances by one per such eviction and wraps after the last slot.
- R7: A fill whose page number and process identifier are already cached overwrites that entry, including its frame and flags, and does not consume another slot.
- R8: Any lookup hit sets the entry's referenced flag, and later lookups report it as set.
- R9: A write lookup that hits a writable entry whose dirty flag is clear pulses dirty-set in that cycle and sets the stored dirty flag. Later write hits on it do not pulse dirty-set again.
- R10: A write lookup that hits a non-writable entry raises the protection-fault output in that cycle and leaves the entry's dirty flag clear.
- R11: The flush command empties every slot, whatever process owns it.
- R12: The invalidate command clears only the entries whose owner tag equals the current process identifier. Entries owned by other processes keep hitting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| cur_pid_i | input | PID_W | Identifier of the running process |
| lk_valid_i | input | 1 | Lookup request |
| lk_write_i | input | 1 | Lookup is for a store |
| lk_vpn_i | input | VPN_W | Virtual page number to translate |
| lk_off_i | input | OFF_W | Byte offset within the page |
| lk_hit_o | output | 1 | Translation found |
| lk_miss_trap_o | output | 1 | Translation absent; software refill needed |
| lk_pa_o | output | PFN_W+OFF_W | Physical address on a hit, zero otherwise |
| lk_writable_o | output | 1 | Writable flag of the hit entry |
| lk_referenced_o | output | 1 | Referenced flag of the hit entry |
| lk_dirty_o | output | 1 | Dirty flag of the hit entry |
| prot_fault_o | output | 1 | Write hit on a non-writable entry |
| dirty_set_o | output | 1 | Write hit that sets a clear dirty flag |
| fill_en_i | input | 1 | Install an entry this cycle |
| fill_vpn_i | input | VPN_W | Page number to install |
| fill_pid_i | input | PID_W | Owner process identifier to install |
| fill_pfn_i | input | PFN_W | Frame number to install |
| fill_writable_i | input | 1 | Writable flag to install |
| fill_referenced_i | input | 1 | Referenced flag to install |
| fill_dirty_i | input | 1 | Dirty flag to install |
| flush_i | input | 1 | Empty every slot |
| inv_pid_i | input | 1 | Clear valid on slots owned by the current process |

## Verification
Lookups are driven as reads and as writes, against pages that are present, absent, and present only under another process. This separates a tag compare that ignores the owner from one that checks it. Fill sequences first use up the empty slots, then re-install an already cached pair, then force four evictions in a row. Checking which pages survive tells a correct in-place overwrite apart from a duplicated entry, and shows whether the victim pointer rotates and wraps. Flush is issued with entries of two owners cached, and invalidate with one owner selected. Repeated write hits tell the first dirtying apart from later ones and from faults on read-only pages.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic writable;
    logic referenced;
    logic dirty;
  } pte_flags_t;

  localparam int FLAG_W = $bits(pte_flags_t);
endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
  import tlb_pkg::*;
#(
  parameter int VPN_W = 11,
  parameter int PFN_W = 19,
  parameter int PID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             inv_pid_i,
  input  logic [PID_W-1:0] cur_pid_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic             lk_touch_i,
  input  logic             lk_dirty_i,
  input  logic             fill_we_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PID_W-1:0] fill_pid_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  pte_flags_t       fill_flags_i,
  output logic             valid_o,
  output logic [PFN_W-1:0] pfn_o,
  output pte_flags_t       flags_o,
  output logic             lk_match_o,
  output logic             fill_match_o
);
  logic             valid_q, valid_d;
  logic [VPN_W-1:0] vpn_q, vpn_d;
  logic [PID_W-1:0] pid_q, pid_d;
  logic [PFN_W-1:0] pfn_q, pfn_d;
  pte_flags_t       flags_q, flags_d;
  logic             own_inv;
  logic             slot_en;

  assign own_inv = inv_pid_i && valid_q && (pid_q == cur_pid_i);
  assign slot_en = flush_i || own_inv || fill_we_i || lk_touch_i || lk_dirty_i;

  always_comb begin
    valid_d = valid_q;
    vpn_d   = vpn_q;
    pid_d   = pid_q;
    pfn_d   = pfn_q;
    flags_d = flags_q;
    if (flush_i) begin
      valid_d = 1'b0;
      vpn_d   = '0;
      pid_d   = '0;
      pfn_d   = '0;
      flags_d = '0;
    end else if (own_inv) begin
      valid_d = 1'b0;
    end else if (fill_we_i) begin
      valid_d = 1'b1;
      vpn_d   = fill_vpn_i;
      pid_d   = fill_pid_i;
      pfn_d   = fill_pfn_i;
      flags_d = fill_flags_i;
    end else begin
      if (lk_touch_i) flags_d.referenced = 1'b1;
      if (lk_dirty_i) flags_d.dirty      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vpn_q   <= '0;
      pid_q   <= '0;
      pfn_q   <= '0;
      flags_q <= '0;
    end else if (slot_en) begin
      valid_q <= valid_d;
      vpn_q   <= vpn_d;
      pid_q   <= pid_d;
      pfn_q   <= pfn_d;
      flags_q <= flags_d;
    end
  end

  assign valid_o      = valid_q;
  assign pfn_o        = pfn_q;
  assign flags_o      = flags_q;
  assign lk_match_o   = valid_q && (vpn_q == lk_vpn_i) && (pid_q == cur_pid_i);
  assign fill_match_o = valid_q && (vpn_q == fill_vpn_i) && (pid_q == fill_pid_i);

  AST_FILL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we_i && !flush_i && !own_inv) |=> (valid_q && vpn_q == $past(fill_vpn_i) && pfn_q == $past(fill_pfn_i))); // R5
  AST_INV_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_pid_i && valid_q && pid_q == cur_pid_i) |=> !valid_q); // R12
  AST_DIRTY_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    lk_dirty_i |-> (valid_q && flags_q.writable)); // R10
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en_i,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] dup_i,
  output logic [ENTRIES-1:0] sel_o
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0]   rr_q, rr_d;
  logic               rr_en;
  logic [ENTRIES-1:0] free_oh;
  logic [ENTRIES-1:0] rr_oh;
  logic               any_free;
  logic               any_dup;

  assign any_free = ~&valid_i;
  assign any_dup  = |dup_i;

  always_comb begin
    free_oh = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        free_oh    = '0;
        free_oh[i] = 1'b1;
      end
    end
  end

  always_comb begin
    rr_oh        = '0;
    rr_oh[rr_q]  = 1'b1;
  end

  always_comb begin
    if (any_dup)       sel_o = dup_i;
    else if (any_free) sel_o = free_oh;
    else               sel_o = rr_oh;
  end

  assign rr_en = fill_en_i && !any_dup && !any_free;
  assign rr_d  = (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rr_q <= '0;
    else if (rr_en) rr_q <= rr_d;
  end

  AST_VICTIM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en_i |-> $onehot(sel_o)); // R6
  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && !any_dup && any_free) |-> ((sel_o & valid_i) == '0)); // R5
endmodule

// File: rtl/tlb_sel_mux.sv
module tlb_sel_mux #(
  parameter int N  = 64,
  parameter int DW = 22
) (
  input  logic [N-1:0]         sel_i,
  input  logic [N-1:0][DW-1:0] din_i,
  output logic [DW-1:0]        dout_o
);
  always_comb begin
    dout_o = '0;
    for (int i = 0; i < N; i++) begin
      dout_o = dout_o | (din_i[i] & {DW{sel_i[i]}});
    end
  end
endmodule

// File: rtl/ptag_tlb.sv
module ptag_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 11,
  parameter int PFN_W   = 19,
  parameter int PID_W   = 8,
  parameter int OFF_W   = 13
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PID_W-1:0]       cur_pid_i,
  input  logic                   lk_valid_i,
  input  logic                   lk_write_i,
  input  logic [VPN_W-1:0]       lk_vpn_i,
  input  logic [OFF_W-1:0]       lk_off_i,
  output logic                   lk_hit_o,
  output logic                   lk_miss_trap_o,
  output logic [PFN_W+OFF_W-1:0] lk_pa_o,
  output logic                   lk_writable_o,
  output logic                   lk_referenced_o,
  output logic                   lk_dirty_o,
  output logic                   prot_fault_o,
  output logic                   dirty_set_o,
  input  logic                   fill_en_i,
  input  logic [VPN_W-1:0]       fill_vpn_i,
  input  logic [PID_W-1:0]       fill_pid_i,
  input  logic [PFN_W-1:0]       fill_pfn_i,
  input  logic                   fill_writable_i,
  input  logic                   fill_referenced_i,
  input  logic                   fill_dirty_i,
  input  logic                   flush_i,
  input  logic                   inv_pid_i
);
  localparam int RD_W = PFN_W + FLAG_W;

  logic                       rst_meta_q, rst_sync_q;
  logic [ENTRIES-1:0]         valid_vec;
  logic [ENTRIES-1:0]         hit_vec;
  logic [ENTRIES-1:0]         dup_vec;
  logic [ENTRIES-1:0]         fill_sel;
  logic [ENTRIES-1:0][RD_W-1:0] rd_bus;
  logic [RD_W-1:0]            rd_data;
  logic [PFN_W-1:0]           hit_pfn;
  pte_flags_t                 hit_flags;
  pte_flags_t                 fill_flags;
  logic                       hit;
  logic                       wr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign fill_flags = '{writable: fill_writable_i, referenced: fill_referenced_i, dirty: fill_dirty_i};
  assign hit        = lk_valid_i && (|hit_vec);
  assign hit_pfn    = rd_data[RD_W-1:FLAG_W];
  assign hit_flags  = pte_flags_t'(rd_data[FLAG_W-1:0]);
  assign wr_ok      = lk_valid_i && lk_write_i && hit_flags.writable && !hit_flags.dirty;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic [PFN_W-1:0] slot_pfn;
    pte_flags_t       slot_flags;

    tlb_slot #(
      .VPN_W (VPN_W),
      .PFN_W (PFN_W),
      .PID_W (PID_W)
    ) u_slot (
      .clk          (clk),
      .rst_n        (rst_sync_q),
      .flush_i      (flush_i),
      .inv_pid_i    (inv_pid_i),
      .cur_pid_i    (cur_pid_i),
      .lk_vpn_i     (lk_vpn_i),
      .lk_touch_i   (lk_valid_i && hit_vec[g]),
      .lk_dirty_i   (wr_ok && hit_vec[g]),
      .fill_we_i    (fill_en_i && fill_sel[g]),
      .fill_vpn_i   (fill_vpn_i),
      .fill_pid_i   (fill_pid_i),
      .fill_pfn_i   (fill_pfn_i),
      .fill_flags_i (fill_flags),
      .valid_o      (valid_vec[g]),
      .pfn_o        (slot_pfn),
      .flags_o      (slot_flags),
      .lk_match_o   (hit_vec[g]),
      .fill_match_o (dup_vec[g])
    );

    assign rd_bus[g] = {slot_pfn, slot_flags};
  end

  tlb_victim #(
    .ENTRIES (ENTRIES)
  ) u_victim (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .fill_en_i (fill_en_i),
    .valid_i   (valid_vec),
    .dup_i     (dup_vec),
    .sel_o     (fill_sel)
  );

  tlb_sel_mux #(
    .N  (ENTRIES),
    .DW (RD_W)
  ) u_rd_mux (
    .sel_i  (hit_vec),
    .din_i  (rd_bus),
    .dout_o (rd_data)
  );

  assign lk_hit_o        = hit;
  assign lk_miss_trap_o  = lk_valid_i && !(|hit_vec);
  assign lk_pa_o         = hit ? {hit_pfn, lk_off_i} : '0;
  assign lk_writable_o   = hit && hit_flags.writable;
  assign lk_referenced_o = hit && hit_flags.referenced;
  assign lk_dirty_o      = hit && hit_flags.dirty;
  assign prot_fault_o    = hit && lk_write_i && !hit_flags.writable;
  assign dirty_set_o     = hit && wr_ok;

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $onehot0(hit_vec)); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_sync_q)
    flush_i |=> (valid_vec == '0)); // R11
  AST_FAULT_NO_DIRTY: assert property (@(posedge clk) disable iff (!rst_sync_q)
    prot_fault_o |-> !dirty_set_o); // R10
endmodule

// File: tb/ptag_tlb_tb.sv
`timescale 1ns/1ps
module ptag_tlb_tb;
  localparam int ENTRIES = 4;
  localparam int VPN_W   = 11;
  localparam int PFN_W   = 19;
  localparam int PID_W   = 8;
  localparam int OFF_W   = 13;
  localparam int PA_W    = PFN_W + OFF_W;

  typedef struct {
    logic            hit;
    logic            miss;
    logic [PA_W-1:0] pa;
    logic            w, r, d, flt, ds;
    string           tag;
  } exp_t;

  logic             clk;
  logic             rst_n;
  logic [PID_W-1:0] cur_pid;
  logic             lk_valid, lk_write;
  logic [VPN_W-1:0] lk_vpn;
  logic [OFF_W-1:0] lk_off;
  logic             lk_hit, lk_miss;
  logic [PA_W-1:0]  lk_pa;
  logic             lk_w, lk_r, lk_d, flt, ds;
  logic             fill_en;
  logic [VPN_W-1:0] fill_vpn;
  logic [PID_W-1:0] fill_pid;
  logic [PFN_W-1:0] fill_pfn;
  logic             fill_w, fill_r, fill_d;
  logic             flush, inv_pid;

  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;
  exp_t exp_q[$];

  ptag_tlb #(
    .ENTRIES (ENTRIES), .VPN_W (VPN_W), .PFN_W (PFN_W), .PID_W (PID_W), .OFF_W (OFF_W)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .cur_pid_i (cur_pid),
    .lk_valid_i (lk_valid), .lk_write_i (lk_write), .lk_vpn_i (lk_vpn), .lk_off_i (lk_off),
    .lk_hit_o (lk_hit), .lk_miss_trap_o (lk_miss), .lk_pa_o (lk_pa),
    .lk_writable_o (lk_w), .lk_referenced_o (lk_r), .lk_dirty_o (lk_d),
    .prot_fault_o (flt), .dirty_set_o (ds),
    .fill_en_i (fill_en), .fill_vpn_i (fill_vpn), .fill_pid_i (fill_pid), .fill_pfn_i (fill_pfn),
    .fill_writable_i (fill_w), .fill_referenced_i (fill_r), .fill_dirty_i (fill_d),
    .flush_i (flush), .inv_pid_i (inv_pid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic look(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off, input logic wr,
                      input logic ehit, input logic [PFN_W-1:0] epfn,
                      input logic ew, input logic er, input logic ed,
                      input logic eflt, input logic eds, input string tag);
    exp_t e;
    @(negedge clk);
    lk_valid = 1'b1; lk_write = wr; lk_vpn = vpn; lk_off = off;
    e.hit = ehit; e.miss = !ehit; e.pa = ehit ? {epfn, off} : '0;
    e.w = ew; e.r = er; e.d = ed; e.flt = eflt; e.ds = eds; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    lk_valid = 1'b0; lk_write = 1'b0;
  endtask

  task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid,
                      input logic [PFN_W-1:0] pfn, input logic w);
    @(negedge clk);
    fill_en = 1'b1; fill_vpn = vpn; fill_pid = pid; fill_pfn = pfn;
    fill_w = w; fill_r = 1'b0; fill_d = 1'b0;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic pulse_inv();
    @(negedge clk); inv_pid = 1'b1;
    @(negedge clk); inv_pid = 1'b0;
  endtask

  // Monitor: samples 2 ns after each falling edge, ahead of the next rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        logic [PA_W+6:0] act, expv;
        e = exp_q.pop_front();
        act  = {lk_hit, lk_miss, lk_pa, lk_w, lk_r, lk_d, flt, ds};
        expv = {e.hit, e.miss, e.pa, e.w, e.r, e.d, e.flt, e.ds};
        n_run++;
        if (act !== expv) begin
          n_fail++;
          $display("FAIL %s: actual hit=%b miss=%b pa=%h w=%b r=%b d=%b flt=%b ds=%b expected hit=%b miss=%b pa=%h w=%b r=%b d=%b flt=%b ds=%b",
                   e.tag, lk_hit, lk_miss, lk_pa, lk_w, lk_r, lk_d, flt, ds,
                   e.hit, e.miss, e.pa, e.w, e.r, e.d, e.flt, e.ds);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cur_pid = 8'd5;
    lk_valid = 0; lk_write = 0; lk_vpn = '0; lk_off = '0;
    fill_en = 0; fill_vpn = '0; fill_pid = '0; fill_pfn = '0; fill_w = 0; fill_r = 0; fill_d = 0;
    flush = 0; inv_pid = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    look(11'd3, 13'h0abc, 0, 0, '0, 0, 0, 0, 0, 0, "R1 empty after reset");
    fill(11'd3, 8'd5, 19'h01234, 1);                       // slot 0
    look(11'd3, 13'h0abc, 0, 1, 19'h01234, 1, 0, 0, 0, 0, "R2 R5 first hit");
    look(11'd3, 13'h1fff, 0, 1, 19'h01234, 1, 1, 0, 0, 0, "R8 referenced set");
    look(11'd4, 13'h0010, 0, 0, '0, 0, 0, 0, 0, 0, "R3 miss trap");
    look(11'd3, 13'h0001, 1, 1, 19'h01234, 1, 1, 0, 0, 1, "R9 first write dirties");
    look(11'd3, 13'h0002, 1, 1, 19'h01234, 1, 1, 1, 0, 0, "R9 second write no pulse");
    fill(11'd7, 8'd5, 19'h00077, 0);                       // slot 1, read-only
    look(11'd7, 13'h0003, 1, 1, 19'h00077, 0, 0, 0, 1, 0, "R10 protection fault");
    look(11'd7, 13'h0004, 0, 1, 19'h00077, 0, 1, 0, 0, 0, "R10 dirty stays clear");
    fill(11'd3, 8'd9, 19'h00999, 1);                       // slot 2, other owner
    look(11'd3, 13'h0005, 0, 1, 19'h01234, 1, 1, 1, 0, 0, "R4 own pid frame");
    @(negedge clk); cur_pid = 8'd9;
    look(11'd3, 13'h0006, 0, 1, 19'h00999, 1, 0, 0, 0, 0, "R4 other pid frame");
    look(11'd7, 13'h0007, 0, 0, '0, 0, 0, 0, 0, 0, "R4 foreign page misses");
    pulse_inv();
    look(11'd3, 13'h0008, 0, 0, '0, 0, 0, 0, 0, 0, "R12 own entries cleared");
    @(negedge clk); cur_pid = 8'd5;
    look(11'd3, 13'h0009, 0, 1, 19'h01234, 1, 1, 1, 0, 0, "R12 other owner survives");

    fill(11'd10, 8'd5, 19'h0000a, 1);                      // lowest free: slot 2
    fill(11'd3, 8'd5, 19'h04444, 0);                       // overwrite slot 0
    look(11'd3, 13'h000a, 0, 1, 19'h04444, 0, 0, 0, 0, 0, "R7 overwrite in place");
    fill(11'd11, 8'd5, 19'h0000b, 1);                      // slot 3, now full
    fill(11'd12, 8'd5, 19'h0000c, 1);                      // evicts slot 0
    look(11'd3, 13'h000b, 0, 0, '0, 0, 0, 0, 0, 0, "R6 slot 0 evicted first");
    look(11'd7, 13'h000c, 0, 1, 19'h00077, 0, 1, 0, 0, 0, "R7 no duplicate slot used");
    look(11'd10, 13'h000d, 0, 1, 19'h0000a, 1, 0, 0, 0, 0, "R5 free slot fill kept");
    fill(11'd13, 8'd5, 19'h0000d, 1);                      // evicts slot 1
    look(11'd7, 13'h000e, 0, 0, '0, 0, 0, 0, 0, 0, "R6 slot 1 evicted next");
    fill(11'd14, 8'd5, 19'h0000e, 1);                      // evicts slot 2
    fill(11'd15, 8'd5, 19'h0000f, 1);                      // evicts slot 3
    fill(11'd16, 8'd5, 19'h00010, 1);                      // wraps: evicts slot 0
    look(11'd12, 13'h000f, 0, 0, '0, 0, 0, 0, 0, 0, "R6 pointer wraps");
    look(11'd13, 13'h0010, 0, 1, 19'h0000d, 1, 0, 0, 0, 0, "R6 slot 1 kept after wrap");
    look(11'd16, 13'h0011, 0, 1, 19'h00010, 1, 0, 0, 0, 0, "R6 wrapped fill visible");

    fill(11'd20, 8'd9, 19'h00020, 1);                      // evicts slot 1
    pulse_flush();
    look(11'd16, 13'h0012, 0, 0, '0, 0, 0, 0, 0, 0, "R11 flush pid 5");
    @(negedge clk); cur_pid = 8'd9;
    look(11'd20, 13'h0013, 0, 0, '0, 0, 0, 0, 0, 0, "R11 flush pid 9");

    @(negedge clk); #2;
    n_run++;
    if ({lk_hit, lk_miss, flt, ds} !== 4'b0000) begin
      n_fail++;
      $display("FAIL R3 idle outputs: actual %b expected 0000", {lk_hit, lk_miss, flt, ds});
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule